// File: doc/BRIEF.md
# Soft-Start Power-Up Sequencer

This block orders the start-up of a two-phase switching regulator controller. A tick arrives at every half of a switching period, and the block counts full switching cycles from these ticks. While the sequence runs it places each PWM channel in one of three output modes. The first mode floats the driver. The second clamps the lower switch. The third lets the pulse-width comparator run. The block also ramps an 8-bit reference code for the error-amplifier DAC and a duty-cycle ceiling, both starting from zero. It raises power-good only once the full start-up delay has elapsed.

A supply-ok input from an external power-on-reset comparator gates the whole sequence. That comparator asserts supply-ok above 4.375 V and withdraws it below 3.875 V. Whenever supply-ok drops, the outputs float at once and the count restarts. The block gives each channel its own start pulse, on opposite half-ticks, so the two phases run 180 degrees apart. The ripple therefore sits at twice the per-channel rate. At a 200 kHz switching rate the 2048-cycle delay lasts 10.24 ms.

Top module: `soft_start_seq`

## Requirements
- R1: While supply_ok is low, in the same clock cycle, mode_a and mode_b are 2'b00 (three-state), pgood is 0, ref_code is 0 and duty_limit is 0. Half-ticks received during that time have no effect: the completed-cycle count stays at zero.
- R2: Mode encoding is 2'b00 three-state, 2'b01 forced low and 2'b10 active PWM. While 0 to 31 full cycles have completed since supply_ok rose (cycles 1 to 32), both modes are 2'b00 and ref_code is 0.
- R3: While 32 to 181 full cycles have completed (the 150-cycle hold-low window), both modes are 2'b01, and ref_code and duty_limit are 0.
- R4: Once 182 or more full cycles have completed, both modes are 2'b10. Each full cycle that completes in active mode raises duty_limit by 1, and duty_limit saturates at 255.
- R5: For every 6 full cycles completed in active mode, ref_code steps up by 1. It saturates at target_code. With the default settings it reaches any 8-bit target before pgood rises.
- R6: pgood is 1 exactly when 2047 or more full cycles have completed, which means from the start of the 2048th cycle, while supply_ok stays high.
- R7: The cycle count saturates at 2048 and does not wrap. pgood stays high for as long as ticks keep coming.
- R8: A full cycle is two half-ticks. start_a pulses with the first half-tick of each cycle and start_b with the second. Either pulse occurs only in active mode, and the two never coincide.
- R9: After supply_ok is lost and then restored, the sequence restarts from cycle 1. Modes return to three-state, and ref_code and duty_limit restart at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above its power-on threshold |
| half_tick | input | 1 | One-clock pulse at each half switching period |
| target_code | input | 8 | Programmed final reference code |
| mode_a | output | 2 | Output mode of channel A |
| mode_b | output | 2 | Output mode of channel B |
| start_a | output | 1 | Channel A pulse-start strobe |
| start_b | output | 1 | Channel B pulse-start strobe |
| ref_code | output | 8 | Reference DAC code |
| duty_limit | output | 8 | Maximum allowed duty code |
| pgood | output | 1 | Power-good flag |

## Verification
The bench drops supply_ok during the three-state window, during the hold-low window and partway up the ramp. Each time it expects the outputs to float in the same cycle and the count to restart. A design that cleared only on the next edge, or that resumed a partial ramp, would show a stale mode or a non-zero ref_code. The bench also probes the exact boundaries at 32 and 182 completed cycles and the rise of pgood at 2047, where an off-by-one design misses by one full cycle. It checks both saturation ends, and it spaces the half-ticks both back to back and with gaps, so that a design mixing up which half-tick ends a cycle would swap or double the channel start strobes.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    MODE_HIZ = 2'b00,
    MODE_LOW = 2'b01,
    MODE_RUN = 2'b10
  } out_mode_e;
endpackage

// File: rtl/ss_cycle_counter.sv
module ss_cycle_counter #(
  parameter int CNT_W = 12,
  parameter int LIMIT = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             half_tick,
  output logic             second_half,
  output logic             cyc_done,
  output logic [CNT_W-1:0] cycles
);
  logic             phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sat;

  assign sat      = (cnt_q >= CNT_W'(LIMIT));
  assign cyc_done = run & half_tick & phase_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (!run) begin
      phase_d = 1'b0;
      cnt_d   = '0;
    end else if (half_tick) begin
      phase_d = ~phase_q;
      if (phase_q && !sat) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign second_half = phase_q;
  assign cycles      = cnt_q;
endmodule

// File: rtl/ss_phase_decode.sv
module ss_phase_decode
  import ss_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int NUM_CH     = 2,
  parameter int TRI_CYCLES = 32,
  parameter int RUN_START  = 182,
  parameter int PG_CYCLE   = 2048
) (
  input  logic                  run,
  input  logic                  half_tick,
  input  logic                  second_half,
  input  logic [CNT_W-1:0]      cycles,
  output logic [NUM_CH-1:0][1:0] modes,
  output logic [NUM_CH-1:0]     starts,
  output logic                  run_phase,
  output logic                  pgood
);
  out_mode_e stage;

  always_comb begin
    if (!run)                                stage = MODE_HIZ;
    else if (cycles < CNT_W'(TRI_CYCLES))    stage = MODE_HIZ;
    else if (cycles < CNT_W'(RUN_START))     stage = MODE_LOW;
    else                                     stage = MODE_RUN;
  end

  assign run_phase = (stage == MODE_RUN);
  assign pgood     = run && (cycles >= CNT_W'(PG_CYCLE - 1));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign modes[ch]  = stage;
    assign starts[ch] = run_phase && half_tick && (second_half == ch[0]);
  end
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int CODE_W   = 8,
  parameter int DUTY_W   = 8,
  parameter int RAMP_DIV = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              step_en,
  input  logic [CODE_W-1:0] target,
  output logic [CODE_W-1:0] ref_code,
  output logic [DUTY_W-1:0] duty_limit
);
  localparam int DIV_W = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;
  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;

  logic [DIV_W-1:0]  div_q, div_d;
  logic [CODE_W-1:0] ref_q, ref_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic              div_wrap;

  assign div_wrap = (div_q == DIV_W'(RAMP_DIV - 1));

  always_comb begin
    div_d  = div_q;
    ref_d  = ref_q;
    duty_d = duty_q;
    if (!run) begin
      div_d  = '0;
      ref_d  = '0;
      duty_d = '0;
    end else if (step_en) begin
      if (duty_q != DUTY_MAX) duty_d = duty_q + 1'b1;
      if (div_wrap) begin
        div_d = '0;
        if (ref_q < target) ref_d = ref_q + 1'b1;
        else                ref_d = target;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ref_q  <= '0;
      duty_q <= '0;
    end else begin
      div_q  <= div_d;
      ref_q  <= ref_d;
      duty_q <= duty_d;
    end
  end

  assign ref_code   = run ? ref_q  : '0;
  assign duty_limit = run ? duty_q : '0;
endmodule

// File: rtl/soft_start_seq.sv
module soft_start_seq #(
  parameter int TRI_CYCLES  = 32,
  parameter int HOLD_CYCLES = 150,
  parameter int PG_CYCLE    = 2048,
  parameter int RAMP_DIV    = 6,
  parameter int CODE_W      = 8,
  parameter int DUTY_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              half_tick,
  input  logic [CODE_W-1:0] target_code,
  output logic [1:0]        mode_a,
  output logic [1:0]        mode_b,
  output logic              start_a,
  output logic              start_b,
  output logic [CODE_W-1:0] ref_code,
  output logic [DUTY_W-1:0] duty_limit,
  output logic              pgood
);
  localparam int CNT_W     = $clog2(PG_CYCLE + 1);
  localparam int RUN_START = TRI_CYCLES + HOLD_CYCLES;
  localparam int NUM_CH    = 2;

  logic                   second_half;
  logic                   cyc_done;
  logic [CNT_W-1:0]       cycles;
  logic [NUM_CH-1:0][1:0] modes;
  logic [NUM_CH-1:0]      starts;
  logic                   run_phase;

  ss_cycle_counter #(.CNT_W(CNT_W), .LIMIT(PG_CYCLE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(supply_ok), .half_tick(half_tick),
    .second_half(second_half), .cyc_done(cyc_done), .cycles(cycles)
  );

  ss_phase_decode #(
    .CNT_W(CNT_W), .NUM_CH(NUM_CH), .TRI_CYCLES(TRI_CYCLES),
    .RUN_START(RUN_START), .PG_CYCLE(PG_CYCLE)
  ) u_dec (
    .run(supply_ok), .half_tick(half_tick), .second_half(second_half),
    .cycles(cycles), .modes(modes), .starts(starts),
    .run_phase(run_phase), .pgood(pgood)
  );

  ss_ramp #(.CODE_W(CODE_W), .DUTY_W(DUTY_W), .RAMP_DIV(RAMP_DIV)) u_ramp (
    .clk(clk), .rst_n(rst_n), .run(supply_ok),
    .step_en(cyc_done & run_phase), .target(target_code),
    .ref_code(ref_code), .duty_limit(duty_limit)
  );

  assign mode_a  = modes[0];
  assign mode_b  = modes[1];
  assign start_a = starts[0];
  assign start_b = starts[1];
endmodule

// File: rtl/ss_seq_checker.sv
module ss_seq_checker #(
  parameter int CODE_W = 8,
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_ok,
  input logic [CODE_W-1:0] target_code,
  input logic [1:0]        mode_a,
  input logic [1:0]        mode_b,
  input logic              start_a,
  input logic              start_b,
  input logic [CODE_W-1:0] ref_code,
  input logic [DUTY_W-1:0] duty_limit,
  input logic              pgood
);
  AST_OFF_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (mode_a == 2'b00 && mode_b == 2'b00 && !pgood && ref_code == '0)); // R1

  AST_NO_DUAL_START: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_a && start_b)); // R8

  AST_START_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_a || start_b) |-> (mode_a == 2'b10)); // R8

  AST_PG_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (mode_a == 2'b10 && mode_b == 2'b10)); // R6

  AST_REF_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok |=> (!supply_ok || ref_code >= $past(ref_code))); // R5

  AST_REF_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok |-> (ref_code <= target_code)); // R5

  AST_DUTY_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok |=> (!supply_ok || (duty_limit - $past(duty_limit)) <= DUTY_W'(1))); // R4

  AST_PG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pgood && supply_ok) |=> (pgood || !supply_ok)); // R7
endmodule

bind soft_start_seq ss_seq_checker #(.CODE_W(CODE_W), .DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .target_code(target_code),
  .mode_a(mode_a), .mode_b(mode_b), .start_a(start_a), .start_b(start_b),
  .ref_code(ref_code), .duty_limit(duty_limit), .pgood(pgood)
);

// File: tb/tb_soft_start_seq.sv
module tb_soft_start_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TRI_N  = 32;
  localparam int RUN_AT = 182;
  localparam int PG_AT  = 2047;
  localparam int SAT_AT = 2048;
  localparam int DIV    = 6;

  logic       clk, rst_n, supply_ok, half_tick;
  logic [7:0] target_code;
  logic [1:0] mode_a, mode_b;
  logic       start_a, start_b, pgood;
  logic [7:0] ref_code, duty_limit;

  int vectors = 0;
  int errors  = 0;
  int cycles_run = 0;

  // behavioural model state
  int m_phase = 0, m_cyc = 0, m_div = 0, m_ref = 0, m_duty = 0;

  soft_start_seq dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .half_tick(half_tick),
    .target_code(target_code), .mode_a(mode_a), .mode_b(mode_b),
    .start_a(start_a), .start_b(start_b), .ref_code(ref_code),
    .duty_limit(duty_limit), .pgood(pgood)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int    e_mode;
    string mtag;
    if (!supply_ok)          begin e_mode = 0; mtag = "R1"; end
    else if (m_cyc < TRI_N)  begin e_mode = 0; mtag = "R2"; end
    else if (m_cyc < RUN_AT) begin e_mode = 1; mtag = "R3"; end
    else                     begin e_mode = 2; mtag = "R4"; end
    check(mtag, "mode_a", int'(mode_a), e_mode);
    check(mtag, "mode_b", int'(mode_b), e_mode);
    check(supply_ok ? "R5" : "R1", "ref_code", int'(ref_code), supply_ok ? m_ref : 0);
    check(supply_ok ? "R4" : "R1", "duty_limit", int'(duty_limit), supply_ok ? m_duty : 0);
    check(supply_ok ? "R6" : "R1", "pgood", int'(pgood), (supply_ok && m_cyc >= PG_AT) ? 1 : 0);
    check("R8", "start_a", int'(start_a),
          (e_mode == 2 && half_tick && m_phase == 0) ? 1 : 0);
    check("R8", "start_b", int'(start_b),
          (e_mode == 2 && half_tick && m_phase == 1) ? 1 : 0);
  endtask

  task automatic model_edge();
    if (!rst_n || !supply_ok) begin
      m_phase = 0; m_cyc = 0; m_div = 0; m_ref = 0; m_duty = 0;
    end else if (half_tick) begin
      if (m_phase == 0) m_phase = 1;
      else begin
        m_phase = 0;
        if (m_cyc >= RUN_AT) begin
          if (m_duty < 255) m_duty++;
          if (m_div == DIV - 1) begin
            m_div = 0;
            if (m_ref < int'(target_code)) m_ref++;
          end else m_div++;
        end
        if (m_cyc < SAT_AT) m_cyc++;
      end
    end
  endtask

  task automatic step(logic sok, logic ht);
    @(negedge clk);
    supply_ok = sok;
    half_tick = ht;
    #1;
    if (rst_n) compare_all();
    @(posedge clk);
    model_edge();
  endtask

  // one full switching cycle: first half-tick back to back, second after a gap
  task automatic run_cycles(int n, logic sok);
    for (int i = 0; i < n; i++) begin
      step(sok, 1'b1);
      if (i % 3 == 0) step(sok, 1'b0);
      step(sok, 1'b1);
      step(sok, 1'b0);
      if (i % 2 == 0) step(sok, 1'b0);
      cycles_run++;
    end
  endtask

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; half_tick = 1'b0; target_code = 8'd200;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset mode_a", int'(mode_a), 0);
    check("R1", "reset pgood", int'(pgood), 0);
    check("R1", "reset ref_code", int'(ref_code), 0);
    @(negedge clk); rst_n = 1'b1;

    run_cycles(5, 1'b0);                 // R1: ticks ignored while supply is low
    run_cycles(20, 1'b1);                // inside three-state window
    run_cycles(1, 1'b0);                 // drop during R2 window
    run_cycles(100, 1'b1);               // R3 window entered
    run_cycles(1, 1'b0);
    target_code = 8'd10;
    run_cycles(400, 1'b1);               // small target, saturates (R5)
    check("R5", "ref saturated at small target", int'(ref_code), 10);
    run_cycles(1, 1'b0);
    target_code = 8'd200;
    step(1'b1, 1'b0);
    check("R9", "mode after restore", int'(mode_a), 0);
    check("R9", "ref after restore", int'(ref_code), 0);
    check("R9", "duty after restore", int'(duty_limit), 0);
    run_cycles(2100, 1'b1);
    check("R7", "pgood held past saturation", int'(pgood), 1);
    check("R5", "ref at target", int'(ref_code), 200);
    check("R4", "duty saturated", int'(duty_limit), 255);
    step(1'b0, 1'b0);
    check("R1", "pgood drops with supply", int'(pgood), 0);
    check("R1", "mode_b floats with supply", int'(mode_b), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired after %0d cycles", cycles_run);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule